// File: doc/BRIEF.md
# Transactional Write Buffer with Conflict Abort

This block lets one requester group a series of memory reads and writes into a single all-or-nothing update. A begin command opens a transaction and stores a fallback address. Inside the transaction, writes go into a private buffer of address/data entries instead of memory. Reads are answered from that buffer when it holds the address, and from memory otherwise. Every address read is recorded in a read set.

A second port stands for the other agents in the system. It can read the memory array and write to it. Buffered data stays invisible on this port until a commit. On commit, the buffer is copied into memory one entry per clock. For that whole burst the external port is held off, so no agent can see a partly applied update.

An external write to any address in the read set or in the write buffer ends the transaction, and so does an explicit abort command or a write that finds the buffer full. An aborted transaction drops all buffered data. The block then presents the stored fallback address and a two-bit reason code, so the requester can branch to its recovery path.

Top module: `tx_commit_unit`

## Requirements
- R1: After reset, `tx_active`, `rsp_valid`, `commit_done` and `abort_pulse` are 0, `req_ready` and `ext_ready` are 1, `abort_reason` is 00, and every memory word reads 0.
- R2: A begin request (`req_op` 1) accepted outside a transaction sets `tx_active` from the next cycle, stores `req_fallback`, and clears `abort_reason` to 00. A begin inside a transaction is ignored.
- R3: A write (`req_op` 3) inside a transaction does not change the memory seen on the external port until the transaction commits.
- R4: A read (`req_op` 2) returns its data on `rsp_rdata` with `rsp_valid` high in the cycle after acceptance. Inside a transaction, an address held in the write buffer returns the buffered value; any other address returns the memory value.
- R5: The write buffer holds `NENT` (8) entries. A repeated write to a buffered address overwrites that entry in place and uses no new entry, also when the buffer is full.
- R6: A commit (`req_op` 4) with N buffered entries holds `ext_ready` and `req_ready` low for exactly N cycles, after which all N values are in memory and `commit_done` pulses for one cycle with `tx_active` low. With N = 0 the commit completes in one cycle with no stall.
- R7: An accepted external write (`ext_valid`, `ext_we`, `ext_ready`) to an address read in the open transaction aborts it: in the next cycle `abort_pulse` is 1, `abort_reason` is 10, `resume_addr` equals the stored fallback, `tx_active` is 0, and no buffered write reaches memory. The external write itself is applied.
- R8: An accepted external write to an address held in the write buffer aborts the transaction with reason 10, in the same way.
- R9: An abort request (`req_op` 5) inside a transaction aborts with reason 01 and discards the buffer. The requester outputs are as in R7.
- R10: A write to an address not in the buffer while all `NENT` entries are in use aborts with reason 11 and discards the buffer.
- R11: A commit or abort clears the read set. An external write to an address read only in an earlier transaction does not abort the current one.
- R12: Outside a transaction, reads and writes go straight to memory, and commit and abort requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester command valid |
| req_ready | output | 1 | Requester command accepted; low during a commit burst |
| req_op | input | 3 | 0 none, 1 begin, 2 read, 3 write, 4 commit, 5 abort |
| req_addr | input | AW | Word address for read and write |
| req_wdata | input | DW | Write data |
| req_fallback | input | FW | Fallback address captured by begin |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| tx_active | output | 1 | Transaction open, including the commit burst |
| commit_done | output | 1 | One-cycle pulse when a commit has completed |
| abort_pulse | output | 1 | One-cycle pulse when a transaction is aborted |
| abort_reason | output | 2 | 00 none, 01 explicit, 10 conflict, 11 buffer full; held until the next begin |
| resume_addr | output | FW | Stored fallback address |
| ext_valid | input | 1 | External access valid |
| ext_ready | output | 1 | External access accepted; low during a commit burst |
| ext_we | input | 1 | External access is a write |
| ext_addr | input | AW | External word address |
| ext_wdata | input | DW | External write data |
| ext_rdata | output | DW | Memory word at `ext_addr`, combinational |

## Verification
The bound checker checks these rules on every cycle: a read response always follows an accepted read; an abort always carries a nonzero reason and leaves the block idle; a commit completion never comes together with an abort; a stalled external port only occurs inside a transaction; a new transaction starts with a cleared reason; and an overflow abort only happens when the buffer was full. Only the bench scenarios can show whether data is invisible on the external port, how long each commit burst lasts, whether buffered data is forwarded, whether an entry is overwritten in place, and whether aborted data is really thrown away. All of these need expected memory contents that the bench works out itself.

// File: rtl/txn_pkg.sv
package txn_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_BEGIN  = 3'd1,
        OP_READ   = 3'd2,
        OP_WRITE  = 3'd3,
        OP_COMMIT = 3'd4,
        OP_ABORT  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'b00,
        RSN_SW       = 2'b01,
        RSN_CONFLICT = 2'b10,
        RSN_FULL     = 2'b11
    } reason_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TX    = 2'd1,
        ST_DRAIN = 2'd2
    } state_e;

endpackage

// File: rtl/txn_mem.sv
// Word array with a core port and an external port; core write wins on a tie.
module txn_mem #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_we,
    input  logic [AW-1:0] core_waddr,
    input  logic [DW-1:0] core_wdata,
    input  logic [AW-1:0] core_raddr,
    output logic [DW-1:0] core_rdata,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_waddr,
    input  logic [DW-1:0] ext_wdata,
    input  logic [AW-1:0] ext_raddr,
    output logic [DW-1:0] ext_rdata
);
    logic [DEPTH-1:0][DW-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (ext_we)  mem_d[ext_waddr]  = ext_wdata;
        if (core_we) mem_d[core_waddr] = core_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign core_rdata = mem_q[core_raddr];
    assign ext_rdata  = mem_q[ext_raddr];
endmodule

// File: rtl/txn_rset.sv
// Read set kept as one bit per memory word.
module txn_rset #(
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          mark_en,
    input  logic [AW-1:0] mark_addr,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit
);
    logic [DEPTH-1:0] bits_q, bits_d;

    always_comb begin
        bits_d = bits_q;
        if (clear)        bits_d = '0;
        else if (mark_en) bits_d[mark_addr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign probe_hit = bits_q[probe_addr];
endmodule

// File: rtl/txn_wbuf.sv
// Private write buffer: entries fill in order, a hit overwrites in place.
module txn_wbuf #(
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int NENT = 8,
    localparam int CW  = $clog2(NENT + 1),
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          put_en,
    input  logic [AW-1:0] look_addr,
    input  logic [DW-1:0] put_data,
    output logic          look_hit,
    output logic [DW-1:0] look_data,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_hit,
    output logic          full,
    output logic [CW-1:0] count,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [NENT-1:0][AW-1:0] addr;
        logic [NENT-1:0][DW-1:0] data;
        logic [CW-1:0]           cnt;
    } wb_t;

    wb_t           s_q, s_d;
    logic [IW-1:0] hit_idx;

    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        snp_hit   = 1'b0;
        hit_idx   = '0;
        for (int i = 0; i < NENT; i++) begin
            if (CW'(i) < s_q.cnt) begin
                if (s_q.addr[i] == look_addr) begin
                    look_hit  = 1'b1;
                    look_data = s_q.data[i];
                    hit_idx   = IW'(i);
                end
                if (s_q.addr[i] == snp_addr) snp_hit = 1'b1;
            end
        end
    end

    assign full = (s_q.cnt == CW'(NENT));

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.cnt = '0;
        end else if (put_en) begin
            if (look_hit) begin
                s_d.data[hit_idx] = put_data;
            end else if (!full) begin
                s_d.addr[s_q.cnt[IW-1:0]] = look_addr;
                s_d.data[s_q.cnt[IW-1:0]] = put_data;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign rd_addr = s_q.addr[rd_idx];
    assign rd_data = s_q.data[rd_idx];
endmodule

// File: rtl/tx_commit_unit.sv
module tx_commit_unit
    import txn_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int NENT = 8,
    parameter int FW   = 12,
    localparam int CW  = $clog2(NENT + 1),
    localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [FW-1:0] req_fallback,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          tx_active,
    output logic          commit_done,
    output logic          abort_pulse,
    output logic [1:0]    abort_reason,
    output logic [FW-1:0] resume_addr,
    input  logic          ext_valid,
    output logic          ext_ready,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] ext_wdata,
    output logic [DW-1:0] ext_rdata
);
    typedef struct packed {
        state_e        st;
        logic [FW-1:0] fb;
        reason_e       rsn;
        logic          abt;
        logic          cdone;
        logic          rv;
        logic [DW-1:0] rd;
        logic [IW-1:0] idx;
    } ctl_t;

    ctl_t q, d;

    // sub-block wires
    logic          wb_put, wb_clr, wb_hit, wb_snp_hit, wb_full;
    logic [DW-1:0] wb_data, wb_rd_data;
    logic [AW-1:0] wb_rd_addr;
    logic [CW-1:0] wb_count;
    logic          rs_mark, rs_clr, rs_hit;
    logic          core_we;
    logic [AW-1:0] core_waddr;
    logic [DW-1:0] core_wdata, mem_rdata;

    logic acc, ext_wr, addr_match, conflict;
    op_e  op;

    assign op        = op_e'(req_op);
    assign req_ready = (q.st != ST_DRAIN);
    assign ext_ready = (q.st != ST_DRAIN);
    assign acc       = req_valid && req_ready;
    assign ext_wr    = ext_valid && ext_ready && ext_we;

    // a read or write issued in the same cycle as a remote write counts too
    assign addr_match = acc && ((op == OP_READ) || (op == OP_WRITE)) && (req_addr == ext_addr);
    assign conflict   = (q.st == ST_TX) && ext_wr && (rs_hit || wb_snp_hit || addr_match);

    always_comb begin
        d          = q;
        d.abt      = 1'b0;
        d.cdone    = 1'b0;
        d.rv       = 1'b0;
        wb_put     = 1'b0;
        wb_clr     = 1'b0;
        rs_mark    = 1'b0;
        rs_clr     = 1'b0;
        core_we    = 1'b0;
        core_waddr = req_addr;
        core_wdata = req_wdata;

        unique case (q.st)
            ST_IDLE: begin
                if (acc) begin
                    unique case (op)
                        OP_BEGIN: begin
                            d.st  = ST_TX;
                            d.fb  = req_fallback;
                            d.rsn = RSN_NONE;
                        end
                        OP_READ: begin
                            d.rv = 1'b1;
                            d.rd = mem_rdata;
                        end
                        OP_WRITE: core_we = 1'b1;
                        default: ;
                    endcase
                end
            end

            ST_TX: begin
                if (conflict) begin
                    d.st  = ST_IDLE;
                    d.abt = 1'b1;
                    d.rsn = RSN_CONFLICT;
                    wb_clr = 1'b1;
                    rs_clr = 1'b1;
                end else if (acc) begin
                    unique case (op)
                        OP_READ: begin
                            d.rv    = 1'b1;
                            d.rd    = wb_hit ? wb_data : mem_rdata;
                            rs_mark = 1'b1;
                        end
                        OP_WRITE: begin
                            if (wb_hit || !wb_full) begin
                                wb_put = 1'b1;
                            end else begin
                                d.st  = ST_IDLE;
                                d.abt = 1'b1;
                                d.rsn = RSN_FULL;
                                wb_clr = 1'b1;
                                rs_clr = 1'b1;
                            end
                        end
                        OP_COMMIT: begin
                            if (wb_count == '0) begin
                                d.st    = ST_IDLE;
                                d.cdone = 1'b1;
                                rs_clr  = 1'b1;
                            end else begin
                                d.st  = ST_DRAIN;
                                d.idx = '0;
                            end
                        end
                        OP_ABORT: begin
                            d.st  = ST_IDLE;
                            d.abt = 1'b1;
                            d.rsn = RSN_SW;
                            wb_clr = 1'b1;
                            rs_clr = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end

            ST_DRAIN: begin
                core_we    = 1'b1;
                core_waddr = wb_rd_addr;
                core_wdata = wb_rd_data;
                if ((CW'(q.idx) + 1'b1) == wb_count) begin
                    d.st    = ST_IDLE;
                    d.cdone = 1'b1;
                    wb_clr  = 1'b1;
                    rs_clr  = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.rsn <= RSN_NONE;
        end else begin
            q <= d;
        end
    end

    txn_wbuf #(.AW(AW), .DW(DW), .NENT(NENT)) wbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (wb_clr),
        .put_en    (wb_put),
        .look_addr (req_addr),
        .put_data  (req_wdata),
        .look_hit  (wb_hit),
        .look_data (wb_data),
        .snp_addr  (ext_addr),
        .snp_hit   (wb_snp_hit),
        .full      (wb_full),
        .count     (wb_count),
        .rd_idx    (q.idx),
        .rd_addr   (wb_rd_addr),
        .rd_data   (wb_rd_data)
    );

    txn_rset #(.AW(AW)) rset_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (rs_clr),
        .mark_en    (rs_mark),
        .mark_addr  (req_addr),
        .probe_addr (ext_addr),
        .probe_hit  (rs_hit)
    );

    txn_mem #(.AW(AW), .DW(DW)) mem_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_we    (core_we),
        .core_waddr (core_waddr),
        .core_wdata (core_wdata),
        .core_raddr (req_addr),
        .core_rdata (mem_rdata),
        .ext_we     (ext_wr),
        .ext_waddr  (ext_addr),
        .ext_wdata  (ext_wdata),
        .ext_raddr  (ext_addr),
        .ext_rdata  (ext_rdata)
    );

    assign rsp_valid    = q.rv;
    assign rsp_rdata    = q.rd;
    assign tx_active    = (q.st != ST_IDLE);
    assign commit_done  = q.cdone;
    assign abort_pulse  = q.abt;
    assign abort_reason = q.rsn;
    assign resume_addr  = q.fb;
endmodule

// File: rtl/txn_chk.sv
module txn_chk #(
    parameter int NENT = 8,
    parameter int CW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [2:0]    req_op,
    input logic          rsp_valid,
    input logic          tx_active,
    input logic          commit_done,
    input logic          abort_pulse,
    input logic [1:0]    abort_reason,
    input logic          ext_ready,
    input logic [CW-1:0] wb_count
);
    assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && (req_op == 3'd2)));

    assert_abort_reason_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> ((abort_reason != 2'b00) && !tx_active));

    assert_commit_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (!tx_active && !abort_pulse));

    assert_stall_in_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ready |-> tx_active);

    assert_begin_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> (abort_reason == 2'b00));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && (abort_reason == 2'b11)) |-> ($past(wb_count) == CW'(NENT)));
endmodule

bind tx_commit_unit txn_chk #(.NENT(NENT), .CW(CW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .rsp_valid    (rsp_valid),
    .tx_active    (tx_active),
    .commit_done  (commit_done),
    .abort_pulse  (abort_pulse),
    .abort_reason (abort_reason),
    .ext_ready    (ext_ready),
    .wb_count     (wb_count)
);

// File: tb/tx_commit_unit_tb_top.sv
module tx_commit_unit_tb_top;
    localparam int AW = 4, DW = 16, NENT = 8, FW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [FW-1:0] req_fallback = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          tx_active, commit_done, abort_pulse;
    logic [1:0]    abort_reason;
    logic [FW-1:0] resume_addr;
    logic          ext_valid = 1'b0;
    logic          ext_ready;
    logic          ext_we = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] ext_wdata = '0;
    logic [DW-1:0] ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    tx_commit_unit #(.AW(AW), .DW(DW), .NENT(NENT), .FW(FW)) dut_i (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic req(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] w, input logic [FW-1:0] fb);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = w; req_fallback = fb;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    task automatic ext_write(input logic [AW-1:0] a, input logic [DW-1:0] w);
        ext_valid = 1'b1; ext_we = 1'b1; ext_addr = a; ext_wdata = w;
        @(negedge clk);
        ext_valid = 1'b0; ext_we = 1'b0;
    endtask

    task automatic ext_read(input logic [AW-1:0] a, output logic [DW-1:0] v);
        ext_addr = a;
        #1 v = ext_rdata;
    endtask

    task automatic t_reset();
        check("R1 tx_active", 32'(tx_active), 0);
        check("R1 req_ready", 32'(req_ready), 1);
        check("R1 ext_ready", 32'(ext_ready), 1);
        check("R1 reason", 32'(abort_reason), 0);
        check("R1 rsp_valid", 32'(rsp_valid), 0);
    endtask

    task automatic t_plain();
        logic [DW-1:0] v;
        req(3'd3, 4'd3, 16'h1111, '0);
        ext_read(4'd3, v);
        check("R12 direct write", 32'(v), 32'h1111);
        req(3'd2, 4'd3, '0, '0);
        check("R12 direct read valid", 32'(rsp_valid), 1);
        check("R12 direct read data", 32'(rsp_rdata), 32'h1111);
        req(3'd4, '0, '0, '0);
        check("R12 commit ignored", 32'(commit_done), 0);
        req(3'd5, '0, '0, '0);
        check("R12 abort ignored", 32'(abort_pulse), 0);
        check("R12 still idle", 32'(tx_active), 0);
    endtask

    task automatic t_sw_abort();
        logic [DW-1:0] v;
        req(3'd1, '0, '0, 12'h0AB);
        req(3'd3, 4'd9, 16'h9999, '0);
        req(3'd5, '0, '0, '0);
        check("R9 pulse", 32'(abort_pulse), 1);
        check("R9 reason", 32'(abort_reason), 1);
        check("R9 resume", 32'(resume_addr), 32'h0AB);
        check("R9 closed", 32'(tx_active), 0);
        ext_read(4'd9, v);
        check("R9 discarded", 32'(v), 0);
    endtask

    task automatic t_commit();
        logic [DW-1:0] v;
        int n;
        req(3'd1, '0, '0, 12'h123);
        check("R2 active", 32'(tx_active), 1);
        check("R2 reason cleared", 32'(abort_reason), 0);
        req(3'd1, '0, '0, 12'h777);
        check("R2 nested begin ignored", 32'(resume_addr), 32'h123);
        req(3'd3, 4'd5, 16'h00A5, '0);
        req(3'd3, 4'd6, 16'h00B6, '0);
        req(3'd3, 4'd5, 16'h00C5, '0);
        ext_read(4'd5, v);
        check("R3 invisible", 32'(v), 0);
        req(3'd2, 4'd5, '0, '0);
        check("R4 forwarded", 32'(rsp_rdata), 32'h00C5);
        req(3'd2, 4'd3, '0, '0);
        check("R4 from memory", 32'(rsp_rdata), 32'h1111);
        req(3'd4, '0, '0, '0);
        n = 0;
        while (!ext_ready && n < 20) begin
            check("R6 requester stalled", 32'(req_ready), 0);
            n++;
            @(negedge clk);
        end
        check("R5 overwrite in place, drain length", 32'(n), 2);
        check("R6 commit_done", 32'(commit_done), 1);
        check("R6 closed", 32'(tx_active), 0);
        ext_read(4'd5, v);
        check("R6 value 5", 32'(v), 32'h00C5);
        ext_read(4'd6, v);
        check("R6 value 6", 32'(v), 32'h00B6);
        // empty commit: completes at once
        req(3'd1, '0, '0, 12'h010);
        req(3'd4, '0, '0, '0);
        check("R6 empty commit done", 32'(commit_done), 1);
        check("R6 empty commit no stall", 32'(ext_ready), 1);
    endtask

    task automatic t_rset_cleared();
        req(3'd1, '0, '0, 12'h200);
        ext_write(4'd3, 16'h2222);
        check("R11 no abort", 32'(abort_pulse), 0);
        check("R11 still open", 32'(tx_active), 1);
        req(3'd5, '0, '0, '0);
    endtask

    task automatic t_conflict_read();
        logic [DW-1:0] v;
        req(3'd1, '0, '0, 12'h321);
        req(3'd2, 4'd3, '0, '0);
        req(3'd3, 4'd10, 16'h5555, '0);
        ext_write(4'd3, 16'h7777);
        check("R7 pulse", 32'(abort_pulse), 1);
        check("R7 reason", 32'(abort_reason), 2);
        check("R7 resume", 32'(resume_addr), 32'h321);
        check("R7 closed", 32'(tx_active), 0);
        ext_read(4'd10, v);
        check("R7 discarded", 32'(v), 0);
        ext_read(4'd3, v);
        check("R7 external write lands", 32'(v), 32'h7777);
    endtask

    task automatic t_conflict_write();
        logic [DW-1:0] v;
        req(3'd1, '0, '0, 12'h044);
        req(3'd3, 4'd11, 16'h0001, '0);
        ext_write(4'd11, 16'hBEEF);
        check("R8 pulse", 32'(abort_pulse), 1);
        check("R8 reason", 32'(abort_reason), 2);
        check("R8 resume", 32'(resume_addr), 32'h044);
        ext_read(4'd11, v);
        check("R8 external value kept", 32'(v), 32'hBEEF);
    endtask

    task automatic t_overflow();
        logic [DW-1:0] v;
        req(3'd1, '0, '0, 12'h055);
        for (int i = 0; i < NENT; i++) req(3'd3, AW'(i), 16'h00A0 + 16'(i), '0);
        req(3'd3, 4'd0, 16'h0FFF, '0);
        check("R5 overwrite when full", 32'(abort_pulse), 0);
        check("R5 still open", 32'(tx_active), 1);
        req(3'd3, 4'd8, 16'h0888, '0);
        check("R10 pulse", 32'(abort_pulse), 1);
        check("R10 reason", 32'(abort_reason), 3);
        check("R10 resume", 32'(resume_addr), 32'h055);
        ext_read(4'd0, v);
        check("R10 discarded 0", 32'(v), 0);
        ext_read(4'd8, v);
        check("R10 discarded 8", 32'(v), 0);
    endtask

    task automatic t_full_commit();
        logic [DW-1:0] v;
        int n;
        req(3'd1, '0, '0, 12'h066);
        for (int i = 0; i < NENT; i++) req(3'd3, AW'(i), 16'h0300 + 16'(i), '0);
        ext_read(4'd7, v);
        check("R3 invisible before commit", 32'(v), 0);
        req(3'd4, '0, '0, '0);
        n = 0;
        while (!ext_ready && n < 20) begin
            n++;
            @(negedge clk);
        end
        check("R6 drain length full", 32'(n), NENT);
        check("R6 done full", 32'(commit_done), 1);
        for (int i = 0; i < NENT; i++) begin
            ext_read(AW'(i), v);
            check("R6 full value", 32'(v), 32'h0300 + 32'(i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_sw_abort();
        t_commit();
        t_rset_cleared();
        t_conflict_read();
        t_conflict_write();
        t_overflow();
        t_full_commit();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule